// File: doc/BRIEF.md
# Network Control and Status Register Bank

This block is the byte-wide host register bank of a small Ethernet switch controller. A host reaches four registers through a plain synchronous bus with an address, write data, a write strobe, a read strobe and a registered read data port. The registers are a network control register, a network status register, a transmit control register and a receive control register. Their fields drive the controller's loopback, transmit request, CRC-append disable and receive filter settings.

Three hardware event inputs set sticky status bits: a link change on either port, transmit completion of packet 1 and transmit completion of packet 2. The two transmit-complete bits use one of two clear rules, picked by a control bit. With the bit at 0, a read or a write of 1 clears them. With the bit at 1, only a write of 1 clears them. The link-change bit is cleared only by a write of 1, or by turning its report enable off.

A software reset starts when 1 is written to control bit 0. It holds the reset output high for a fixed 10 us window, counted in clock cycles from a clock-frequency parameter, and then clears itself. The reset returns the bank to its defaults but keeps the link-change report enable and the link-change status.

Top module: `net_csr_bank`

## Requirements
- R1: After the reset input is released, every register reads 0x00 and every control output is 0.
- R2: The control register at offset 0x00 keeps link-report enable in bit 6, status-clear mode in bit 5 and loopback in bit 1. Bit 7 and bits 4:2 read 0. The `loopbackEn` output follows bit 1.
- R3: Writing 1 to control bit 0 drives `swResetOut` high, and bit 0 reads 1, for exactly CLK_FREQ_HZ/1e6 × RST_US cycles (500 by default). After that the bit returns to 0 by itself.
- R4: The start of a software reset clears loopback, clear mode, the transmit control and receive control registers and both transmit-complete bits. It leaves link-report enable and link-change status untouched.
- R5: The link-change status bit, status bit 5 at offset 0x01, is set by a `linkChangeEvt` pulse only while link-report enable is 1. Pulses while the enable is 0 are ignored.
- R6: Reading the status register never clears link-change status. Writing 1 to bit 5 clears it, and writing 0 does not.
- R7: A control write that sets link-report enable to 0 also clears link-change status.
- R8: `txDone1Evt` sets status bit 2 and `txDone2Evt` sets status bit 3. With clear mode at 0, a status read returns the set bits and then clears them. A write of 1 also clears them.
- R9: With clear mode at 1, status reads leave bits 2 and 3 set. Only writing 1 to a bit clears it.
- R10: A set event in the same cycle as a read-clear or a write-1 clear wins, and the status bit stays set.
- R11: The transmit control register at offset 0x02 holds CRC-disable for packet 2 in bit 3, CRC-disable for packet 1 in bit 1 and the transmit request in bit 0. The other bits read 0. The request clears itself on either transmit-done event.
- R12: The receive control register at offset 0x05 holds accept-all-hash in bit 7, drop-CRC-error in bit 4 and pass-all-multicast in bit 3. The other bits read 0. Each field drives its own output.
- R13: Writes to any offset other than 0x00, 0x01, 0x02 and 0x05 change nothing, and reads of those offsets return 0x00.
- R14: Read data appears on `busRdData` one cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | ADDR_W | Register offset |
| busWrData | input | 8 | Write data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busRdData | output | 8 | Registered read data |
| linkChangeEvt | input | 1 | Link change pulse from either port |
| txDone1Evt | input | 1 | Packet 1 transmit complete pulse |
| txDone2Evt | input | 1 | Packet 2 transmit complete pulse |
| swResetOut | output | 1 | High during the software reset window |
| loopbackEn | output | 1 | Loopback enable |
| txRequest | output | 1 | Transmit request |
| crcDisPkt1 | output | 1 | CRC append disable, packet 1 |
| crcDisPkt2 | output | 1 | CRC append disable, packet 2 |
| rxHashAll | output | 1 | Accept all hash-table addresses |
| rxDropCrcErr | output | 1 | Discard CRC-error frames |
| rxPassMcast | output | 1 | Pass all multicast frames |

## Verification
Register writes and event pulses take effect at the clock edge where they are sampled. Read data is captured at the edge of the read strobe, so it is valid one cycle later. The bench drives inputs on the falling edge and samples results on the next falling edge. The reset window starts with `swResetOut` high after the write edge, and the bench counts falling edges until it drops, expecting exactly RST_US microseconds of cycles. Same-cycle collisions between a set event and a read or write-1 clear are driven in a single cycle, and the following read shows which one won.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int CTL_OFF = 0;
  localparam int STS_OFF = 1;
  localparam int TXC_OFF = 2;
  localparam int RXC_OFF = 5;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTL,
    SEL_STS,
    SEL_TXC,
    SEL_RXC
  } regSelT;

  typedef struct packed {
    logic   wrCtl;
    logic   wrSts;
    logic   wrTxc;
    logic   wrRxc;
    logic   rdSts;
    logic   rdEn;
    regSelT rdSel;
    logic   swRstStart;
    logic   rstBusy;
  } csrStrobeT;
endpackage

// File: rtl/csr_ctrl.sv
module csr_ctrl
  import csr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int RST_US      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              rstBitIn,
  output csrStrobeT         strobe
);
  localparam int RST_CYCLES = (CLK_FREQ_HZ / 1_000_000) * RST_US;
  localparam int CNT_W      = $clog2(RST_CYCLES + 1);

  regSelT          sel;
  logic [CNT_W-1:0] rstCnt;
  logic            busy;
  logic            startRst;

  always_comb begin
    if (busAddr == ADDR_W'(CTL_OFF))      sel = SEL_CTL;
    else if (busAddr == ADDR_W'(STS_OFF)) sel = SEL_STS;
    else if (busAddr == ADDR_W'(TXC_OFF)) sel = SEL_TXC;
    else if (busAddr == ADDR_W'(RXC_OFF)) sel = SEL_RXC;
    else                                  sel = SEL_NONE;
  end

  assign busy     = (rstCnt != '0);
  assign startRst = busWr && (sel == SEL_CTL) && rstBitIn && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rstCnt <= '0;
    else if (startRst) rstCnt <= CNT_W'(RST_CYCLES);
    else if (busy)     rstCnt <= rstCnt - CNT_W'(1);
  end

  always_comb begin
    strobe.wrCtl      = busWr && (sel == SEL_CTL);
    strobe.wrSts      = busWr && (sel == SEL_STS);
    strobe.wrTxc      = busWr && (sel == SEL_TXC);
    strobe.wrRxc      = busWr && (sel == SEL_RXC);
    strobe.rdSts      = busRd && (sel == SEL_STS);
    strobe.rdEn       = busRd;
    strobe.rdSel      = sel;
    strobe.swRstStart = startRst;
    strobe.rstBusy    = busy;
  end

  // R3: a started reset is reported busy on the next cycle
  p_rst_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swRstStart |=> strobe.rstBusy);

  // R3: the window cannot be restarted while it runs
  p_no_restart_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstBusy |-> !strobe.swRstStart);
endmodule

// File: rtl/csr_regs.sv
module csr_regs
  import csr_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  csrStrobeT strobe,
  input  logic [7:0] wrData,
  input  logic      linkChangeEvt,
  input  logic      txDone1Evt,
  input  logic      txDone2Evt,
  output logic [7:0] rdData,
  output logic      loopbackEn,
  output logic      txRequest,
  output logic      crcDisPkt1,
  output logic      crcDisPkt2,
  output logic      rxHashAll,
  output logic      rxDropCrcErr,
  output logic      rxPassMcast
);
  logic linkRptEn, clrByW1Only, loopback;
  logic linkSt, tx1Done, tx2Done;
  logic txReq, crcDis1, crcDis2;
  logic hashAll, dropCrc, passMcast;
  logic tx1Clr, tx2Clr;
  logic [7:0] rdMux;

  // link-report enable survives the software reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             linkRptEn <= 1'b0;
    else if (strobe.wrCtl) linkRptEn <= wrData[6];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clrByW1Only <= 1'b0;
      loopback    <= 1'b0;
    end else if (strobe.swRstStart) begin
      clrByW1Only <= 1'b0;
      loopback    <= 1'b0;
    end else if (strobe.wrCtl) begin
      clrByW1Only <= wrData[5];
      loopback    <= wrData[1];
    end
  end

  // link-change status: enable turned off clears, set beats write-1 clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              linkSt <= 1'b0;
    else if (strobe.wrCtl && !wrData[6])    linkSt <= 1'b0;
    else if (linkChangeEvt && linkRptEn)    linkSt <= 1'b1;
    else if (strobe.wrSts && wrData[5])     linkSt <= 1'b0;
  end

  assign tx1Clr = (strobe.wrSts && wrData[2]) || (strobe.rdSts && !clrByW1Only)
                  || strobe.swRstStart;
  assign tx2Clr = (strobe.wrSts && wrData[3]) || (strobe.rdSts && !clrByW1Only)
                  || strobe.swRstStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tx1Done <= 1'b0;
      tx2Done <= 1'b0;
    end else begin
      if (txDone1Evt)  tx1Done <= 1'b1;
      else if (tx1Clr) tx1Done <= 1'b0;
      if (txDone2Evt)  tx2Done <= 1'b1;
      else if (tx2Clr) tx2Done <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReq   <= 1'b0;
      crcDis1 <= 1'b0;
      crcDis2 <= 1'b0;
    end else if (strobe.swRstStart) begin
      txReq   <= 1'b0;
      crcDis1 <= 1'b0;
      crcDis2 <= 1'b0;
    end else if (strobe.wrTxc) begin
      txReq   <= wrData[0];
      crcDis1 <= wrData[1];
      crcDis2 <= wrData[3];
    end else if (txDone1Evt || txDone2Evt) begin
      txReq   <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hashAll   <= 1'b0;
      dropCrc   <= 1'b0;
      passMcast <= 1'b0;
    end else if (strobe.swRstStart) begin
      hashAll   <= 1'b0;
      dropCrc   <= 1'b0;
      passMcast <= 1'b0;
    end else if (strobe.wrRxc) begin
      hashAll   <= wrData[7];
      dropCrc   <= wrData[4];
      passMcast <= wrData[3];
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_CTL: rdMux = {1'b0, linkRptEn, clrByW1Only, 3'b000, loopback, strobe.rstBusy};
      SEL_STS: rdMux = {2'b00, linkSt, 1'b0, tx2Done, tx1Done, 2'b00};
      SEL_TXC: rdMux = {4'b0000, crcDis2, 1'b0, crcDis1, txReq};
      SEL_RXC: rdMux = {hashAll, 2'b00, dropCrc, passMcast, 3'b000};
      default: rdMux = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdData <= 8'h00;
    else if (strobe.rdEn) rdData <= rdMux;
  end

  assign loopbackEn   = loopback;
  assign txRequest    = txReq;
  assign crcDisPkt1   = crcDis1;
  assign crcDisPkt2   = crcDis2;
  assign rxHashAll    = hashAll;
  assign rxDropCrcErr = dropCrc;
  assign rxPassMcast  = passMcast;

  p_link_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!linkRptEn && !linkSt) |=> !linkSt);

  p_en_off_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtl && !wrData[6]) |=> !linkSt);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txDone1Evt || txDone2Evt) |=> ((tx1Done || !$past(txDone1Evt)) && (tx2Done || !$past(txDone2Evt))));

  p_req_selfclr_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txReq && (txDone1Evt || txDone2Evt) && !strobe.wrTxc) |=> !txReq);

  p_unmapped_zero_r13: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn && strobe.rdSel == SEL_NONE) |=> (rdData == 8'h00));
endmodule

// File: rtl/net_csr_bank.sv
module net_csr_bank
  import csr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int RST_US      = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [7:0]        busWrData,
  input  logic              busWr,
  input  logic              busRd,
  output logic [7:0]        busRdData,
  input  logic              linkChangeEvt,
  input  logic              txDone1Evt,
  input  logic              txDone2Evt,
  output logic              swResetOut,
  output logic              loopbackEn,
  output logic              txRequest,
  output logic              crcDisPkt1,
  output logic              crcDisPkt2,
  output logic              rxHashAll,
  output logic              rxDropCrcErr,
  output logic              rxPassMcast
);
  csrStrobeT strobe;

  csr_ctrl #(
    .ADDR_W(ADDR_W),
    .CLK_FREQ_HZ(CLK_FREQ_HZ),
    .RST_US(RST_US)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .busAddr(busAddr),
    .busWr(busWr),
    .busRd(busRd),
    .rstBitIn(busWrData[0]),
    .strobe(strobe)
  );

  csr_regs u_regs (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .wrData(busWrData),
    .linkChangeEvt(linkChangeEvt),
    .txDone1Evt(txDone1Evt),
    .txDone2Evt(txDone2Evt),
    .rdData(busRdData),
    .loopbackEn(loopbackEn),
    .txRequest(txRequest),
    .crcDisPkt1(crcDisPkt1),
    .crcDisPkt2(crcDisPkt2),
    .rxHashAll(rxHashAll),
    .rxDropCrcErr(rxDropCrcErr),
    .rxPassMcast(rxPassMcast)
  );

  assign swResetOut = strobe.rstBusy;
endmodule

// File: tb/tb_net_csr_bank.sv
`timescale 1ns/1ps
module tb_net_csr_bank;
  localparam int RST_CYCLES = 500;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busAddr = 8'h00;
  logic [7:0] busWrData = 8'h00;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busRdData;
  logic       linkChangeEvt = 1'b0;
  logic       txDone1Evt = 1'b0;
  logic       txDone2Evt = 1'b0;
  logic       swResetOut, loopbackEn, txRequest, crcDisPkt1, crcDisPkt2;
  logic       rxHashAll, rxDropCrcErr, rxPassMcast;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  net_csr_bank dut (.*);

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, actual, expected);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdData;
  endtask

  task automatic pulse(input bit lnk, input bit d1, input bit d2);
    @(negedge clk);
    linkChangeEvt = lnk; txDone1Evt = d1; txDone2Evt = d2;
    @(negedge clk);
    linkChangeEvt = 1'b0; txDone1Evt = 1'b0; txDone2Evt = 1'b0;
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    rd(8'h00, d); check("R1 ctl", d, 8'h00);
    rd(8'h01, d); check("R1 sts", d, 8'h00);
    rd(8'h02, d); check("R1 txc", d, 8'h00);
    rd(8'h05, d); check("R1 rxc", d, 8'h00);
    check("R1 outputs", {swResetOut, loopbackEn, txRequest, crcDisPkt1, crcDisPkt2,
                         rxHashAll, rxDropCrcErr, rxPassMcast}, 0);
  endtask

  task automatic t_ctl_fields();
    logic [7:0] d;
    wr(8'h00, 8'hFE);
    rd(8'h00, d); check("R2 ctl fields", d, 8'h62);
    check("R2 loopback out", loopbackEn, 1);
    wr(8'h00, 8'h40);
    rd(8'h00, d); check("R2 ctl clear", d, 8'h40);
    check("R2 loopback off", loopbackEn, 0);
  endtask

  task automatic t_link();
    logic [7:0] d;
    wr(8'h00, 8'h00);
    pulse(1, 0, 0);
    rd(8'h01, d); check("R5 ignored while disabled", d, 8'h00);
    wr(8'h00, 8'h40);
    pulse(1, 0, 0);
    rd(8'h01, d); check("R5 set while enabled", d, 8'h20);
    rd(8'h01, d); check("R6 read keeps link", d, 8'h20);
    wr(8'h01, 8'h00);
    rd(8'h01, d); check("R6 write 0 keeps link", d, 8'h20);
    wr(8'h01, 8'h20);
    rd(8'h01, d); check("R6 write 1 clears link", d, 8'h00);
    pulse(1, 0, 0);
    wr(8'h00, 8'h00);
    rd(8'h01, d); check("R7 enable off clears link", d, 8'h00);
  endtask

  task automatic t_tx_cor();
    logic [7:0] d;
    wr(8'h00, 8'h00);
    pulse(0, 1, 1);
    rd(8'h01, d); check("R8 read returns set bits", d, 8'h0C);
    rd(8'h01, d); check("R8 cleared by read", d, 8'h00);
    pulse(0, 1, 1);
    wr(8'h01, 8'h04);
    @(negedge clk);
    busAddr = 8'h00; busRd = 1'b0;
    wr(8'h00, 8'h20);
    rd(8'h01, d); check("R8 write 1 clears only bit 2", d, 8'h08);
    wr(8'h01, 8'h08);
  endtask

  task automatic t_tx_w1c();
    logic [7:0] d;
    wr(8'h00, 8'h20);
    pulse(0, 1, 1);
    rd(8'h01, d); check("R9 read sees bits", d, 8'h0C);
    rd(8'h01, d); check("R9 read does not clear", d, 8'h0C);
    wr(8'h01, 8'h0C);
    rd(8'h01, d); check("R9 write 1 clears", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(8'h00, 8'h00);
    pulse(0, 1, 0);
    @(negedge clk);
    busAddr = 8'h01; busRd = 1'b1; txDone1Evt = 1'b1;
    @(negedge clk);
    busRd = 1'b0; txDone1Evt = 1'b0;
    check("R10 read shows old bit", busRdData, 8'h04);
    rd(8'h01, d); check("R10 set beats read clear", d, 8'h04);
    wr(8'h00, 8'h20);
    @(negedge clk);
    busAddr = 8'h01; busWrData = 8'h08; busWr = 1'b1; txDone2Evt = 1'b1;
    @(negedge clk);
    busWr = 1'b0; txDone2Evt = 1'b0;
    rd(8'h01, d); check("R10 set beats write-1 clear", d, 8'h08);
    wr(8'h01, 8'h0C);
  endtask

  task automatic t_txc();
    logic [7:0] d;
    wr(8'h02, 8'hFF);
    rd(8'h02, d); check("R11 txc fields", d, 8'h0B);
    check("R11 outputs", {txRequest, crcDisPkt1, crcDisPkt2}, 3'b111);
    pulse(0, 0, 1);
    rd(8'h02, d); check("R11 request self clears", d, 8'h0A);
    check("R11 request output", txRequest, 0);
    wr(8'h02, 8'h01);
    pulse(0, 1, 0);
    check("R11 clears on packet 1 done", txRequest, 0);
    wr(8'h01, 8'h0C);
  endtask

  task automatic t_rxc();
    logic [7:0] d;
    wr(8'h05, 8'hFF);
    rd(8'h05, d); check("R12 rxc fields", d, 8'h98);
    check("R12 outputs", {rxHashAll, rxDropCrcErr, rxPassMcast}, 3'b111);
    wr(8'h05, 8'h10);
    check("R12 partial outputs", {rxHashAll, rxDropCrcErr, rxPassMcast}, 3'b010);
  endtask

  task automatic t_unmapped();
    logic [7:0] d;
    wr(8'h00, 8'h42);
    wr(8'h02, 8'h0A);
    wr(8'h05, 8'h88);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] a;
      a = (i == 0) ? 8'h03 : (i == 1) ? 8'h04 : (i == 2) ? 8'h06 : 8'h81;
      wr(a, 8'hFF);
      rd(a, d); check("R13 unmapped read zero", d, 8'h00);
    end
    rd(8'h00, d); check("R13 ctl untouched", d, 8'h42);
    rd(8'h01, d); check("R13 sts untouched", d, 8'h00);
    rd(8'h02, d); check("R13 txc untouched", d, 8'h0A);
    rd(8'h05, d); check("R13 rxc untouched", d, 8'h88);
  endtask

  task automatic t_read_timing();
    logic [7:0] d;
    rd(8'h05, d); check("R14 data after one cycle", d, 8'h88);
    wr(8'h05, 8'h08);
    repeat (3) @(negedge clk);
    check("R14 data held without read", busRdData, 8'h88);
    rd(8'h05, d); check("R14 new data on next read", d, 8'h08);
  endtask

  task automatic t_soft_reset();
    logic [7:0] d;
    int n;
    wr(8'h00, 8'h62);
    pulse(1, 1, 0);
    wr(8'h02, 8'h0B);
    wr(8'h05, 8'h98);
    wr(8'h00, 8'h63);
    n = 0;
    while (swResetOut && n < 2 * RST_CYCLES) begin
      n++;
      @(negedge clk);
    end
    check("R3 reset window length", n, RST_CYCLES);
    rd(8'h00, d); check("R4 ctl keeps enable only", d, 8'h40);
    rd(8'h01, d); check("R4 link kept tx cleared", d, 8'h20);
    rd(8'h02, d); check("R4 txc cleared", d, 8'h00);
    rd(8'h05, d); check("R4 rxc cleared", d, 8'h00);
    check("R4 loopback cleared", loopbackEn, 0);
    wr(8'h00, 8'h41);
    rd(8'h00, d); check("R3 bit 0 reads 1 during reset", d, 8'h41);
    while (swResetOut) @(negedge clk);
    rd(8'h00, d); check("R3 bit 0 self clears", d, 8'h40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset_state();
    t_ctl_fields();
    t_link();
    t_tx_cor();
    t_tx_w1c();
    t_priority();
    t_txc();
    t_rxc();
    t_unmapped();
    t_read_timing();
    t_soft_reset();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule